// File: doc/BRIEF.md
# Hibernate Power-Down Controller

This block lives in the always-on domain of a chip and controls entry into and exit from a deep hibernate state. Software asks for hibernation by writing a power-down request to the control register. If the clock-select status is zero, the block drops its power-on output at once, and the core and IO supplies are cut. A request made while the clock-select status is nonzero is discarded.

While the block is hibernating, its wakeup pin passes through a synchroniser and then a pulse-width filter. A wakeup only counts once the synchronised pin has been active for a programmed number of consecutive cycles. On a qualified wakeup the block raises the power-on output again and, in the same edge, asserts an active-low hibernate reset. That reset is held for a programmed number of cycles. When it is released, the power-down request clears and a flag records that the core came back through a hibernate reset, so software can tell it apart from a power-on reset.

Top module: `hib_pwr_ctrl`

## Requirements
- R1: After the asynchronous power-on reset `rst_n`, `pwr_on`=1, `hib_rst_n`=1, `pd_state`=0 and `hib_flag`=0, and both count registers read as 0. A power-on reset taken during hibernation also restores `pwr_on`=1 and leaves `hib_flag`=0.
- R2: A write to address 0 with data bit 0 set, made in the run state while `clk_sel` is all zero, sets `pd_state` and drops `pwr_on` on that same clock edge.
- R3: The same power-down write is ignored when `clk_sel` is nonzero: `pwr_on` stays 1 and `pd_state` stays 0.
- R4: While hibernating or in the hibernate reset, writes to any address are ignored, and the programmed counts keep their values.
- R5: `wake_in` passes through `SYNC_STG` flip-flops. A wakeup qualifies on the edge where the synchronised input has been 1 for N consecutive cycles, where N is the filter count (address 1, with 0 treated as 1). With `SYNC_STG`=2 and N=3, `pwr_on` rises on the 5th edge after `wake_in` goes high. Any low synchronised cycle restarts the count, so a shorter pulse leaves `pwr_on`=0.
- R6: On a qualified wakeup, `pwr_on` rises and `hib_rst_n` falls on the same edge. `hib_rst_n` then stays 0 for exactly M cycles, where M is the reset count (address 2, with 0 treated as 1). `hib_rst_n` is never 0 while `pwr_on` is 0.
- R7: On the edge that releases `hib_rst_n`, `pd_state` clears and `hib_flag` sets.
- R8: `hib_flag` is cleared only by `rst_n` or by a run-state write to address 0 with data bit 1 set. Entering hibernation does not clear it.
- R9: `wake_in` has no effect outside hibernation: `pwr_on` and `hib_rst_n` stay 1.
- R10: Run-state writes to address 1 load the filter count and writes to address 2 load the reset count, each taking `wr_data[CNT_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 filter count, 2 reset count |
| wr_data | input | CNT_W | Write data; control bit 0 requests power-down, bit 1 clears the flag |
| clk_sel | input | CSEL_W | Clock-select status; power-down is allowed only when zero |
| wake_in | input | 1 | Asynchronous wakeup pin, active high |
| pwr_on | output | 1 | Core and IO supply enable |
| hib_rst_n | output | 1 | Active-low hibernate reset to the core |
| pd_state | output | 1 | Power-down request bit |
| hib_flag | output | 1 | Last core restart was a hibernate reset |

## Verification
A filter counter that is off by one moves the rising edge of `pwr_on` by one cycle relative to the wakeup pulse. A filter counter that fails to clear lets a short pulse wake the part, and that shows at `pwr_on` within the filter window. A reset counter that is off by one stretches or shortens the low phase of `hib_rst_n`, which shows on the very edge of its release. A state register that accepts writes it should ignore only shows at the next wakeup, through a changed latency or pulse length. The bench therefore compares all four outputs against a behavioural model on every clock.

// File: rtl/hib_pkg.sv
package hib_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_HIB = 2'd1,
    ST_RST = 2'd2
  } hib_st_e;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_FILT = 2'd1;
  localparam logic [1:0] A_RLEN = 2'd2;

  localparam int CTL_PD   = 0;
  localparam int CTL_FCLR = 1;

endpackage

// File: rtl/hib_regs.sv
module hib_regs
  import hib_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] filt_lim,
  output logic [CNT_W-1:0] rst_len
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] filt_q, filt_d;
  logic [CNT_W-1:0] rlen_q, rlen_d;
  logic             filt_en, rlen_en;

  always_comb begin
    filt_en = accept && wr_en && (wr_addr == A_FILT);
    rlen_en = accept && wr_en && (wr_addr == A_RLEN);
    filt_d  = wr_data;
    rlen_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      rlen_q <= '0;
    end else begin
      if (filt_en) filt_q <= filt_d;
      if (rlen_en) rlen_q <= rlen_d;
    end
  end

  // zero is treated as one cycle
  assign filt_lim = (filt_q == '0) ? ONE : filt_q;
  assign rst_len  = (rlen_q == '0) ? ONE : rlen_q;

endmodule

// File: rtl/hib_wake_filt.sv
module hib_wake_filt #(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_in,
  input  logic             arm,
  input  logic [CNT_W-1:0] lim,
  output logic             qual
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STG-1:0] sync_q;
  logic                wake_s;

  for (genvar g = 0; g < SYNC_STG; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= wake_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign wake_s = sync_q[SYNC_STG-1];

  logic [CNT_W-1:0] fc_q, fc_d;
  logic             fc_en;

  always_comb begin
    qual  = arm && wake_s && (fc_q >= lim - ONE);
    fc_en = 1'b1;
    if (!arm || !wake_s || qual) fc_d = '0;
    else                         fc_d = fc_q + ONE;
    if (fc_d == fc_q) fc_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fc_q <= '0;
    else if (fc_en) fc_q <= fc_d;
  end

endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_wr,
  input  logic              fclr_wr,
  input  logic [CSEL_W-1:0] clk_sel,
  input  logic              qual,
  input  logic [CNT_W-1:0]  rst_len,
  output hib_st_e           state,
  output logic              pwr_on,
  output logic              hib_rst_n,
  output logic              pd_state,
  output logic              hib_flag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  hib_st_e          st_q, st_d;
  logic             pd_q, pd_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] rc_q, rc_d;
  logic             rc_en;

  always_comb begin
    st_d   = st_q;
    pd_d   = pd_q;
    flag_d = flag_q;
    rc_d   = rc_q;
    rc_en  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (fclr_wr) flag_d = 1'b0;
        if (pd_wr && (clk_sel == '0)) begin
          st_d = ST_HIB;
          pd_d = 1'b1;
        end
      end
      ST_HIB: begin
        if (qual) begin
          st_d  = ST_RST;
          rc_d  = '0;
          rc_en = 1'b1;
        end
      end
      ST_RST: begin
        rc_en = 1'b1;
        if (rc_q >= rst_len - ONE) begin
          st_d   = ST_RUN;
          pd_d   = 1'b0;
          flag_d = 1'b1;
          rc_d   = '0;
        end else begin
          rc_d = rc_q + ONE;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      pd_q   <= 1'b0;
      flag_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      st_q   <= st_d;
      pd_q   <= pd_d;
      flag_q <= flag_d;
      if (rc_en) rc_q <= rc_d;
    end
  end

  assign state     = st_q;
  assign pwr_on    = (st_q != ST_HIB);
  assign hib_rst_n = (st_q != ST_RST);
  assign pd_state  = pd_q;
  assign hib_flag  = flag_q;

endmodule

// File: rtl/hib_pwr_ctrl.sv
module hib_pwr_ctrl
  import hib_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CSEL_W   = 2,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [CSEL_W-1:0] clk_sel,
  input  logic              wake_in,
  output logic              pwr_on,
  output logic              hib_rst_n,
  output logic              pd_state,
  output logic              hib_flag
);

  hib_st_e          state;
  logic             run, armed;
  logic             ctl_wr, pd_wr, fclr_wr, qual;
  logic [CNT_W-1:0] filt_lim, rst_len;

  assign run     = (state == ST_RUN);
  assign armed   = (state == ST_HIB);
  assign ctl_wr  = wr_en && (wr_addr == A_CTL);
  assign pd_wr   = ctl_wr && wr_data[CTL_PD];
  assign fclr_wr = ctl_wr && wr_data[CTL_FCLR];

  hib_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (run),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .filt_lim (filt_lim),
    .rst_len  (rst_len)
  );

  hib_wake_filt #(.CNT_W(CNT_W), .SYNC_STG(SYNC_STG)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake_in (wake_in),
    .arm     (armed),
    .lim     (filt_lim),
    .qual    (qual)
  );

  hib_seq #(.CNT_W(CNT_W), .CSEL_W(CSEL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_wr     (pd_wr),
    .fclr_wr   (fclr_wr),
    .clk_sel   (clk_sel),
    .qual      (qual),
    .rst_len   (rst_len),
    .state     (state),
    .pwr_on    (pwr_on),
    .hib_rst_n (hib_rst_n),
    .pd_state  (pd_state),
    .hib_flag  (hib_flag)
  );

endmodule

// File: rtl/hib_chk.sv
module hib_chk
  import hib_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CSEL_W-1:0] clk_sel,
  input logic              pwr_on,
  input logic              hib_rst_n,
  input logic              pd_state,
  input logic              hib_flag
);

  // R3
  gated_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && clk_sel != '0) |=> pwr_on);

  // R2
  off_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> $past(wr_en && wr_addr == A_CTL && wr_data[CTL_PD]));

  // R2
  off_has_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> pd_state);

  // R6
  no_rst_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> hib_rst_n);

  // R6
  wake_enters_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> !hib_rst_n);

  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hib_rst_n) |-> (!pd_state && hib_flag));

endmodule

bind hib_pwr_ctrl hib_chk #(.CNT_W(CNT_W), .CSEL_W(CSEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .clk_sel   (clk_sel),
  .pwr_on    (pwr_on),
  .hib_rst_n (hib_rst_n),
  .pd_state  (pd_state),
  .hib_flag  (hib_flag)
);

// File: tb/test_hib_pwr_ctrl.sv
`timescale 1ns/1ps
module test_hib_pwr_ctrl;

  localparam int CNT_W = 16;
  localparam int CSEL_W = 2;
  localparam int SYNC = 2;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic [CSEL_W-1:0] clk_sel;
  logic              wake_in;
  logic              pwr_on, hib_rst_n, pd_state, hib_flag;

  int total = 0;
  int fails = 0;
  bit done = 0;

  hib_pwr_ctrl #(.CNT_W(CNT_W), .CSEL_W(CSEL_W), .SYNC_STG(SYNC)) i_hib_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .wake_in(wake_in), .pwr_on(pwr_on), .hib_rst_n(hib_rst_n),
    .pd_state(pd_state), .hib_flag(hib_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 run, 1 hibernate, 2 hibernate reset
  int m_st, m_pd, m_flag, m_filt, m_rlen, m_fc, m_rc;
  int msq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pd = 0; m_flag = 0; m_filt = 0; m_rlen = 0; m_fc = 0; m_rc = 0;
      msq = {};
      for (int i = 0; i < SYNC; i++) msq.push_back(0);
    end else begin
      int ws;
      int flim, rlim;
      ws = msq.pop_back();
      msq.push_front(int'(wake_in));
      flim = (m_filt == 0) ? 1 : m_filt;
      rlim = (m_rlen == 0) ? 1 : m_rlen;
      if (m_st == 0) begin
        if (wr_en) begin
          if (wr_addr == 2'd0) begin
            if (wr_data[1]) m_flag = 0;
            if (wr_data[0] && clk_sel == '0) begin m_st = 1; m_pd = 1; end
          end else if (wr_addr == 2'd1) m_filt = int'(wr_data);
          else if (wr_addr == 2'd2) m_rlen = int'(wr_data);
        end
      end else if (m_st == 1) begin
        if (ws == 1) begin
          if (m_fc + 1 >= flim) begin m_st = 2; m_fc = 0; m_rc = 0; end
          else m_fc++;
        end else m_fc = 0;
      end else begin
        if (m_rc + 1 >= rlim) begin m_st = 0; m_pd = 0; m_flag = 1; m_rc = 0; end
        else m_rc++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 pd_state vs model", int'(pd_state), m_pd);
      chk("R5 pwr_on vs model", int'(pwr_on), (m_st != 1) ? 1 : 0);
      chk("R6 hib_rst_n vs model", int'(hib_rst_n), (m_st != 2) ? 1 : 0);
      chk("R8 hib_flag vs model", int'(hib_flag), m_flag);
    end
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold wake high from a negedge; returns negedges until pwr_on rises
  task automatic wake_lat(output int lat);
    wake_in = 1'b1;
    lat = 0;
    while (!pwr_on && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic rst_width(output int w);
    w = 0;
    while (!hib_rst_n && w < 60) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lat, w;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; clk_sel = '0; wake_in = 1'b0;
    #1 rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pwr_on after reset", int'(pwr_on), 1);
    chk("R1 hib_rst_n after reset", int'(hib_rst_n), 1);
    chk("R1 pd_state after reset", int'(pd_state), 0);
    chk("R1 hib_flag after reset", int'(hib_flag), 0);

    // R10 program counts
    wr(2'd1, 3);
    wr(2'd2, 4);

    // R9 wake ignored in run state
    wake_in = 1'b1; idle(6); wake_in = 1'b0; idle(2);
    chk("R9 pwr_on with wake in run", int'(pwr_on), 1);
    chk("R9 hib_rst_n with wake in run", int'(hib_rst_n), 1);

    // R3 blocked by nonzero clock select
    clk_sel = 2'd2;
    wr(2'd0, 1);
    idle(2);
    chk("R3 pwr_on with clk_sel set", int'(pwr_on), 1);
    chk("R3 pd_state with clk_sel set", int'(pd_state), 0);
    clk_sel = '0;

    // R2 enter hibernate
    wr(2'd0, 1);
    chk("R2 pwr_on dropped", int'(pwr_on), 0);
    chk("R2 pd_state set", int'(pd_state), 1);

    // R4 writes while hibernating are ignored
    wr(2'd1, 9);
    wr(2'd2, 9);
    wr(2'd0, 2);

    // R5 short pulse does not wake
    wake_in = 1'b1; idle(2); wake_in = 1'b0; idle(8);
    chk("R5 short pulse keeps power off", int'(pwr_on), 0);

    // R5 qualified wake after SYNC + filter count edges
    wake_lat(lat);
    chk("R5 wake latency filt=3", lat, SYNC + 3);
    chk("R6 reset asserted with power", int'(hib_rst_n), 0);
    rst_width(w);
    wake_in = 1'b0;
    chk("R6 reset width 4 (R4 count kept)", w, 4);
    chk("R7 pd_state cleared at release", int'(pd_state), 0);
    chk("R7 hib_flag set at release", int'(hib_flag), 1);

    // R8 flag survives hibernate entry, cleared by write
    wr(2'd2, 0);
    wr(2'd1, 0);
    wr(2'd0, 1);
    chk("R8 flag kept on entry", int'(hib_flag), 1);
    idle(2);
    wake_lat(lat);
    chk("R5 wake latency filt=0", lat, SYNC + 1);
    rst_width(w);
    wake_in = 1'b0;
    chk("R6 reset width for count 0", w, 1);
    wr(2'd0, 2);
    chk("R8 flag cleared by write", int'(hib_flag), 0);

    // R1 power-on reset during hibernation
    wr(2'd0, 1);
    chk("R2 re-entry pwr_on", int'(pwr_on), 0);
    idle(2);
    rst_n = 1'b0;
    idle(2);
    chk("R1 pwr_on under reset in hibernate", int'(pwr_on), 1);
    chk("R1 hib_flag under reset", int'(hib_flag), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 pd_state after reset", int'(pd_state), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule